// File: doc/BRIEF.md
# I2C Master Byte-Count Transfer Sequencer

This block paces the byte flow of an I2C master transaction. It sits between a host-side register interface and an abstract byte-level bus engine. The bus engine accepts four commands: open a transaction with an address and a direction, send one byte, receive one byte, and close with a stop condition. Each command is a request held until the engine answers with a one-cycle done strobe, an acknowledge bit and, for a receive, a data byte. Bytes pass between the host and the sequencer through a four-entry byte FIFO. The host pushes bytes into it when transmitting and pops bytes from it when receiving.

The host programs a 16-bit control word, a byte count and a 10-bit target address. Two modes exist. In counted mode the running counter is loaded from the programmed count when the address is acknowledged. The transfer ends when the counter reaches zero: with a stop if one was requested, otherwise with an access-ready event that leaves the bus held open for a repeated start. In repeat mode the count is never consumed, and the transfer runs until the host sets the stop bit. A byte or address that the target refuses raises a sticky no-acknowledge event and withdraws any pending stop. The sequencer also reports when it needs transmit data and when receive data is waiting.

Top module: `i2c_byte_seq`

## Requirements
- R1: A control write stores `ctrl_wdata & 16'hCF87` on `ctrl_q`. Bit positions: 15 enable, 14 byte order (stored only), 10 master, 9 transmit, 8 ten-bit address, 2 repeat mode, 1 stop, 0 start.
- R2: A control write while idle, with enable, master and start set and the ten-bit bit clear, begins a transaction. In the next cycle the start bit reads 0, the FIFO is empty, and `bus_req` is high with `bus_cmd`=0 (open), `bus_addr` equal to the address register and `bus_rd` equal to the inverse of bit 9. The other command codes are 1 send, 2 receive, 3 stop.
- R3: If the open is refused, `ev_nack` sets, control bit 1 clears, `bus_open` falls and no further command is issued. If it is acknowledged, `cnt_cur` is loaded from the programmed count.
- R4: In counted transmit mode, one FIFO byte is sent per handshake, in FIFO order, while the counter is nonzero. Each acknowledged byte lowers `cnt_cur` by one.
- R5: `ev_xrdy` is high while a transmit transfer is waiting on an empty FIFO with count left (always counted as left in repeat mode). It is low once the count is used up.
- R6: In counted mode, when the counter reaches zero with bit 1 set, a stop is issued. Bit 1 then clears, `cnt_cur` reloads the programmed count, the transmit FIFO empties and `bus_open` falls. With bit 1 clear, `ev_ardy` sets, bit 10 clears, no stop is issued and `bus_open` stays high. A zero count ends the transfer right after the open.
- R7: In counted receive mode, bytes are received while the counter is nonzero and the FIFO holds fewer than 4. `ev_rrdy` is high while in receive mode with a non-empty FIFO. `rx_data` shows the oldest byte, and `rx_pop` on an empty FIFO is ignored.
- R8: In repeat mode (bit 2) `cnt_cur` never changes during the transfer. Transmit sends every buffered byte, and receive fills the FIFO to 4. Setting bit 1 issues a stop at once. A stop after a receive keeps the received bytes.
- R9: A refused data byte sets `ev_nack`, clears bit 1, is not counted, and halts the sequence with the bus left open and the unsent bytes still in the FIFO.
- R10: A control write with bit 15 clear resets the control word, the programmed and running counts, the address, the events, the FIFO and the bus state to zero.
- R11: `stat_clr[0]` clears `ev_ardy` and `stat_clr[1]` clears `ev_nack`.
- R12: A start written with bit 10 clear or bit 8 set is stored but issues no bus command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 16 | Control word write value |
| cnt_wr | input | 1 | Programmed byte count write strobe |
| cnt_wdata | input | CNT_W | Programmed byte count value |
| sa_wr | input | 1 | Target address write strobe |
| sa_wdata | input | SA_W | Target address value |
| stat_clr | input | 2 | Write-one-to-clear: bit 0 access ready, bit 1 no-acknowledge |
| tx_push | input | 1 | Push a transmit byte into the FIFO |
| tx_data | input | 8 | Transmit byte |
| rx_pop | input | 1 | Pop the oldest FIFO byte |
| rx_data | output | 8 | Oldest FIFO byte |
| buf_level | output | 3 | FIFO occupancy |
| ctrl_q | output | 16 | Current control word |
| cnt_cur | output | CNT_W | Running byte counter |
| bus_req | output | 1 | Bus command request, held until done |
| bus_cmd | output | 2 | Command: 0 open, 1 send, 2 receive, 3 stop |
| bus_addr | output | SA_W | Target address |
| bus_rd | output | 1 | Direction of the open, 1 = read |
| bus_wbyte | output | 8 | Byte to send |
| bus_done | input | 1 | One-cycle completion strobe |
| bus_ack | input | 1 | Acknowledge for the completed command |
| bus_rbyte | input | 8 | Byte received by a receive command |
| bus_open | output | 1 | Bus held by this master |
| ev_ardy | output | 1 | Access ready event (sticky) |
| ev_xrdy | output | 1 | Transmit data needed |
| ev_rrdy | output | 1 | Receive data waiting |
| ev_nack | output | 1 | No-acknowledge event (sticky) |

## Verification
All state is registered. A control, count, address, push, pop or clear write shows on the outputs in the cycle after its strobe, and a start shows `bus_req` in that cycle. After a `bus_done` strobe the request drops at the next edge, and the next command is decided one edge later. So each byte costs the bench's two-cycle bus responder about four cycles. The bench therefore checks register effects right after the writing cycle. It judges multi-byte flows only after a window several times longer than the handshakes it needs, and it then compares the responder's command log, the counters and the events against values worked out from the requirements.

// File: rtl/i2c_byte_seq_pkg.sv
package i2c_byte_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_XFER  = 2'd2,
        ST_STOP  = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        CMD_OPEN = 2'd0,
        CMD_SEND = 2'd1,
        CMD_RECV = 2'd2,
        CMD_STOP = 2'd3
    } bus_cmd_e;

    localparam int CB_EN  = 15;
    localparam int CB_MST = 10;
    localparam int CB_TRX = 9;
    localparam int CB_XA  = 8;
    localparam int CB_RM  = 2;
    localparam int CB_STP = 1;
    localparam int CB_STT = 0;
    localparam logic [15:0] CTRL_KEEP = 16'hCF87;
endpackage

// File: rtl/i2c_byte_seq_buf.sv
module i2c_byte_seq_buf #(
    parameter int DEPTH = 4,
    parameter int W     = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [LW-1:0] level
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           rp;
        logic [PW-1:0]           wp;
        logic [LW-1:0]           lvl;
    } buf_t;

    buf_t buf_d, buf_q;
    logic do_push, do_pop;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        buf_d   = buf_q;
        do_pop  = pop && (buf_q.lvl != '0);
        do_push = push && (buf_q.lvl < LW'(DEPTH));
        if (flush) begin
            buf_d.rp  = '0;
            buf_d.wp  = '0;
            buf_d.lvl = '0;
        end else begin
            if (do_push) begin
                buf_d.mem[buf_q.wp] = push_data;
                buf_d.wp            = ptr_inc(buf_q.wp);
            end
            if (do_pop) begin
                buf_d.rp = ptr_inc(buf_q.rp);
            end
            buf_d.lvl = buf_q.lvl + LW'(do_push) - LW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) buf_q <= '0;
        else        buf_q <= buf_d;
    end

    assign head  = buf_q.mem[buf_q.rp];
    assign level = buf_q.lvl;

    // R7
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0 && pop && !push && !flush) |=> (level == '0));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level == LW'(DEPTH) && push && !pop && !flush) |=> (level == LW'(DEPTH)));
endmodule

// File: rtl/i2c_byte_seq_fsm.sv
module i2c_byte_seq_fsm
    import i2c_byte_seq_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SA_W  = 10,
    parameter int DEPTH = 4,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic [15:0]      ctrl_wdata,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             sa_wr,
    input  logic [SA_W-1:0]  sa_wdata,
    input  logic [1:0]       stat_clr,
    input  logic             bus_done,
    input  logic             bus_ack,
    input  logic [LW-1:0]    buf_level,
    input  logic [7:0]       buf_head,
    output logic             buf_flush,
    output logic             seq_push,
    output logic             seq_pop,
    output logic [15:0]      ctrl_q,
    output logic [CNT_W-1:0] cnt_cur,
    output logic             bus_req,
    output logic [1:0]       bus_cmd,
    output logic [SA_W-1:0]  bus_addr,
    output logic             bus_rd,
    output logic [7:0]       bus_wbyte,
    output logic             bus_open,
    output logic             ev_ardy,
    output logic             ev_xrdy,
    output logic             ev_rrdy,
    output logic             ev_nack
);
    typedef struct packed {
        seq_state_e       st;
        logic [15:0]      ctrl;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] count;
        logic [SA_W-1:0]  sa;
        logic             req;
        bus_cmd_e         cmd;
        logic [7:0]       wbyte;
        logic             rd;
        logic             open;
        logic             ardy;
        logic             nack;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [15:0] wval;
    logic        rm, trx, buf_empty, buf_room;

    assign rm        = seq_q.ctrl[CB_RM];
    assign trx       = seq_q.ctrl[CB_TRX];
    assign buf_empty = (buf_level == '0);
    assign buf_room  = (buf_level < LW'(DEPTH));

    always_comb begin
        seq_d     = seq_q;
        buf_flush = 1'b0;
        seq_push  = 1'b0;
        seq_pop   = 1'b0;
        wval      = ctrl_wdata & CTRL_KEEP;

        if (stat_clr[0]) seq_d.ardy = 1'b0;
        if (stat_clr[1]) seq_d.nack = 1'b0;
        if (cnt_wr)      seq_d.count = cnt_wdata;
        if (sa_wr)       seq_d.sa = sa_wdata;

        case (seq_q.st)
            ST_START: begin
                if (bus_done) begin
                    seq_d.req = 1'b0;
                    if (!bus_ack) begin
                        seq_d.nack         = 1'b1;
                        seq_d.ctrl[CB_STP] = 1'b0;
                        seq_d.open         = 1'b0;
                        seq_d.st           = ST_IDLE;
                    end else begin
                        seq_d.cnt  = seq_q.count;
                        seq_d.open = 1'b1;
                        seq_d.st   = ST_XFER;
                    end
                end
            end
            ST_XFER: begin
                if (seq_q.req) begin
                    if (bus_done) begin
                        seq_d.req = 1'b0;
                        if (seq_q.cmd == CMD_SEND) begin
                            if (bus_ack) begin
                                if (!rm) seq_d.cnt = seq_q.cnt - CNT_W'(1);
                            end else begin
                                seq_d.nack         = 1'b1;
                                seq_d.ctrl[CB_STP] = 1'b0;
                                seq_d.st           = ST_IDLE;
                            end
                        end else begin
                            seq_push = 1'b1;
                            if (!rm) seq_d.cnt = seq_q.cnt - CNT_W'(1);
                        end
                    end
                end else if (seq_q.ctrl[CB_STP] && (rm || seq_q.cnt == '0)) begin
                    seq_d.req = 1'b1;
                    seq_d.cmd = CMD_STOP;
                    seq_d.st  = ST_STOP;
                end else if (!rm && seq_q.cnt == '0) begin
                    seq_d.ardy         = 1'b1;
                    seq_d.ctrl[CB_MST] = 1'b0;
                    seq_d.st           = ST_IDLE;
                end else if (trx && !buf_empty) begin
                    seq_d.req   = 1'b1;
                    seq_d.cmd   = CMD_SEND;
                    seq_d.wbyte = buf_head;
                    seq_pop     = 1'b1;
                end else if (!trx && buf_room) begin
                    seq_d.req = 1'b1;
                    seq_d.cmd = CMD_RECV;
                end
            end
            ST_STOP: begin
                if (bus_done) begin
                    seq_d.req          = 1'b0;
                    seq_d.ctrl[CB_STP] = 1'b0;
                    seq_d.cnt          = seq_q.count;
                    seq_d.open         = 1'b0;
                    seq_d.st           = ST_IDLE;
                    if (trx) buf_flush = 1'b1;
                end
            end
            default: ;
        endcase

        if (ctrl_wr) begin
            if (!wval[CB_EN]) begin
                seq_d     = '0;
                buf_flush = 1'b1;
                seq_push  = 1'b0;
                seq_pop   = 1'b0;
            end else begin
                seq_d.ctrl = wval;
                if (seq_q.st == ST_IDLE && wval[CB_STT] && wval[CB_MST] && !wval[CB_XA]) begin
                    seq_d.ctrl[CB_STT] = 1'b0;
                    seq_d.st           = ST_START;
                    seq_d.req          = 1'b1;
                    seq_d.cmd          = CMD_OPEN;
                    seq_d.rd           = !wval[CB_TRX];
                    buf_flush          = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign ctrl_q    = seq_q.ctrl;
    assign cnt_cur   = seq_q.cnt;
    assign bus_req   = seq_q.req;
    assign bus_cmd   = seq_q.cmd;
    assign bus_addr  = seq_q.sa;
    assign bus_rd    = seq_q.rd;
    assign bus_wbyte = seq_q.wbyte;
    assign bus_open  = seq_q.open;
    assign ev_ardy   = seq_q.ardy;
    assign ev_nack   = seq_q.nack;
    assign ev_xrdy   = (seq_q.st == ST_XFER) && trx && !seq_q.req && buf_empty &&
                       (rm || seq_q.cnt != '0);
    assign ev_rrdy   = !trx && !buf_empty;

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_done && !ctrl_wr) |=> (bus_req && $stable(bus_cmd)));

    // R2
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_START) |-> !ctrl_q[CB_STT]);

    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_XFER && !ctrl_wr) |=>
        (cnt_cur == $past(cnt_cur) || cnt_cur == $past(cnt_cur) - CNT_W'(1)));

    // R8
    repeat_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_XFER && rm && !ctrl_wr) |=> $stable(cnt_cur));

    // R9
    nack_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ev_nack) && !$past(ctrl_wr)) |-> !ctrl_q[CB_STP]);

    // R6
    ardy_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ev_ardy) && !$past(ctrl_wr)) |-> (!ctrl_q[CB_MST] && bus_open));
endmodule

// File: rtl/i2c_byte_seq.sv
module i2c_byte_seq #(
    parameter int CNT_W = 16,
    parameter int SA_W  = 10,
    parameter int DEPTH = 4,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic [15:0]      ctrl_wdata,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             sa_wr,
    input  logic [SA_W-1:0]  sa_wdata,
    input  logic [1:0]       stat_clr,
    input  logic             tx_push,
    input  logic [7:0]       tx_data,
    input  logic             rx_pop,
    output logic [7:0]       rx_data,
    output logic [LW-1:0]    buf_level,
    output logic [15:0]      ctrl_q,
    output logic [CNT_W-1:0] cnt_cur,
    output logic             bus_req,
    output logic [1:0]       bus_cmd,
    output logic [SA_W-1:0]  bus_addr,
    output logic             bus_rd,
    output logic [7:0]       bus_wbyte,
    input  logic             bus_done,
    input  logic             bus_ack,
    input  logic [7:0]       bus_rbyte,
    output logic             bus_open,
    output logic             ev_ardy,
    output logic             ev_xrdy,
    output logic             ev_rrdy,
    output logic             ev_nack
);
    logic       buf_flush, seq_push, seq_pop;
    logic       any_push, any_pop;
    logic [7:0] push_byte, head;

    assign any_push  = seq_push || tx_push;
    assign push_byte = seq_push ? bus_rbyte : tx_data;
    assign any_pop   = seq_pop || rx_pop;
    assign rx_data   = head;

    i2c_byte_seq_buf #(.DEPTH(DEPTH), .W(8)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (buf_flush),
        .push      (any_push),
        .push_data (push_byte),
        .pop       (any_pop),
        .head      (head),
        .level     (buf_level)
    );

    i2c_byte_seq_fsm #(.CNT_W(CNT_W), .SA_W(SA_W), .DEPTH(DEPTH)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (ctrl_wdata),
        .cnt_wr     (cnt_wr),
        .cnt_wdata  (cnt_wdata),
        .sa_wr      (sa_wr),
        .sa_wdata   (sa_wdata),
        .stat_clr   (stat_clr),
        .bus_done   (bus_done),
        .bus_ack    (bus_ack),
        .buf_level  (buf_level),
        .buf_head   (head),
        .buf_flush  (buf_flush),
        .seq_push   (seq_push),
        .seq_pop    (seq_pop),
        .ctrl_q     (ctrl_q),
        .cnt_cur    (cnt_cur),
        .bus_req    (bus_req),
        .bus_cmd    (bus_cmd),
        .bus_addr   (bus_addr),
        .bus_rd     (bus_rd),
        .bus_wbyte  (bus_wbyte),
        .bus_open   (bus_open),
        .ev_ardy    (ev_ardy),
        .ev_xrdy    (ev_xrdy),
        .ev_rrdy    (ev_rrdy),
        .ev_nack    (ev_nack)
    );
endmodule

// File: tb/i2c_byte_seq_tb.sv
module i2c_byte_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NTBL = 6;
    // {write value, expected stored control word}
    localparam logic [31:0] TBL [NTBL] = '{
        {16'hFFFF, 16'hCF87}, {16'h8000, 16'h8000}, {16'hC106, 16'hC106},
        {16'h8201, 16'h8201}, {16'h8E0A, 16'h8E02}, {16'h4F05, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic [15:0] ctrl_wdata = '0;
    logic        cnt_wr = 1'b0;
    logic [15:0] cnt_wdata = '0;
    logic        sa_wr = 1'b0;
    logic [9:0]  sa_wdata = '0;
    logic [1:0]  stat_clr = '0;
    logic        tx_push = 1'b0;
    logic [7:0]  tx_data = '0;
    logic        rx_pop = 1'b0;
    logic [7:0]  rx_data;
    logic [2:0]  buf_level;
    logic [15:0] ctrl_q;
    logic [15:0] cnt_cur;
    logic        bus_req;
    logic [1:0]  bus_cmd;
    logic [9:0]  bus_addr;
    logic        bus_rd;
    logic [7:0]  bus_wbyte;
    logic        bus_done = 1'b0;
    logic        bus_ack = 1'b0;
    logic [7:0]  bus_rbyte = '0;
    logic        bus_open, ev_ardy, ev_xrdy, ev_rrdy, ev_nack;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    int nack_idx = -1;

    logic [1:0] log_cmd [64];
    logic [7:0] log_byte [64];
    int log_n = 0;
    int lat = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    i2c_byte_seq u_dut (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .sa_wr(sa_wr), .sa_wdata(sa_wdata),
        .stat_clr(stat_clr), .tx_push(tx_push), .tx_data(tx_data), .rx_pop(rx_pop),
        .rx_data(rx_data), .buf_level(buf_level), .ctrl_q(ctrl_q), .cnt_cur(cnt_cur),
        .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wbyte(bus_wbyte), .bus_done(bus_done), .bus_ack(bus_ack),
        .bus_rbyte(bus_rbyte), .bus_open(bus_open), .ev_ardy(ev_ardy),
        .ev_xrdy(ev_xrdy), .ev_rrdy(ev_rrdy), .ev_nack(ev_nack)
    );

    // Bus engine model: answers each request two cycles after it appears.
    always @(negedge clk) begin
        if (bus_done) begin
            bus_done <= 1'b0;
            lat      <= 0;
        end else if (bus_req) begin
            if (lat == 1) begin
                bus_done           <= 1'b1;
                bus_ack            <= (log_n != nack_idx);
                bus_rbyte          <= 8'hA0 + log_n[7:0];
                log_cmd[log_n[5:0]]  <= bus_cmd;
                log_byte[log_n[5:0]] <= bus_wbyte;
                log_n              <= log_n + 1;
            end else begin
                lat <= lat + 1;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctrl(input logic [15:0] v);
        @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_wr = 1'b0;
    endtask

    task automatic wr_cnt(input logic [15:0] v);
        @(negedge clk); cnt_wr = 1'b1; cnt_wdata = v;
        @(negedge clk); cnt_wr = 1'b0;
    endtask

    task automatic wr_sa(input logic [9:0] v);
        @(negedge clk); sa_wr = 1'b1; sa_wdata = v;
        @(negedge clk); sa_wr = 1'b0;
    endtask

    task automatic clr(input logic [1:0] v);
        @(negedge clk); stat_clr = v;
        @(negedge clk); stat_clr = '0;
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk); tx_push = 1'b1; tx_data = b;
        @(negedge clk); tx_push = 1'b0;
    endtask

    task automatic pop(output logic [7:0] b);
        @(negedge clk); b = rx_data; rx_pop = 1'b1;
        @(negedge clk); rx_pop = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int base;
        logic [7:0] b;
        cycles(3);
        rst_n = 1'b1;
        cycles(1);

        // Reset state
        chk("R10 reset ctrl", ctrl_q, 0);
        chk("R10 reset cnt", cnt_cur, 0);
        chk("R10 reset req", bus_req, 0);
        chk("R10 reset events", {ev_ardy, ev_xrdy, ev_rrdy, ev_nack}, 0);

        // R1 / R12: table of control writes
        for (int i = 0; i < NTBL; i++) begin
            wr_ctrl(TBL[i][31:16]);
            chk("R1 ctrl mask", ctrl_q, TBL[i][15:0]);
            chk("R12 no command", bus_req, 0);
        end

        // Counted transmit with stop
        base = log_n;
        wr_sa(10'h055);
        wr_cnt(16'd3);
        wr_ctrl(16'h8603);
        chk("R2 start cleared", ctrl_q, 16'h8602);
        chk("R2 req", {bus_req, bus_cmd, bus_rd}, {1'b1, 2'd0, 1'b0});
        chk("R2 addr", bus_addr, 10'h055);
        cycles(10);
        chk("R3 count loaded", cnt_cur, 3);
        chk("R5 xrdy waiting", ev_xrdy, 1);
        push(8'h11); push(8'h22); push(8'h33);
        cycles(40);
        chk("R4 log len", log_n - base, 5);
        chk("R4 open", log_cmd[base], 0);
        chk("R4 byte1", {log_cmd[base+1], log_byte[base+1]}, {2'd1, 8'h11});
        chk("R4 byte2", {log_cmd[base+2], log_byte[base+2]}, {2'd1, 8'h22});
        chk("R4 byte3", {log_cmd[base+3], log_byte[base+3]}, {2'd1, 8'h33});
        chk("R6 stop cmd", log_cmd[base+4], 3);
        chk("R6 stop bit clear", ctrl_q, 16'h8600);
        chk("R6 count reload", cnt_cur, 3);
        chk("R6 bus closed", bus_open, 0);

        // Counted transmit without stop
        base = log_n;
        wr_cnt(16'd2);
        wr_ctrl(16'h8601);
        cycles(10);
        push(8'hA5); push(8'h5A);
        cycles(30);
        chk("R6 no stop log", log_n - base, 3);
        chk("R4 order", {log_byte[base+1], log_byte[base+2]}, {8'hA5, 8'h5A});
        chk("R6 ardy", ev_ardy, 1);
        chk("R6 master cleared", ctrl_q, 16'h8200);
        chk("R6 bus held", bus_open, 1);
        chk("R5 xrdy off at zero", ev_xrdy, 0);
        chk("R4 counter zero", cnt_cur, 0);
        clr(2'b01);
        chk("R11 ardy cleared", ev_ardy, 0);

        // Counted receive, count 5, stop
        base = log_n;
        wr_cnt(16'd5);
        wr_ctrl(16'h8403);
        chk("R2 read dir", bus_rd, 1);
        cycles(40);
        chk("R7 fifo full", buf_level, 4);
        chk("R7 count left", cnt_cur, 1);
        chk("R7 rrdy", ev_rrdy, 1);
        pop(b); chk("R7 rx byte0", b, 8'hA0 + 8'(base + 1));
        pop(b); chk("R7 rx byte1", b, 8'hA0 + 8'(base + 2));
        cycles(30);
        chk("R7 log len", log_n - base, 7);
        chk("R6 rx stop", log_cmd[base+6], 3);
        chk("R6 rx keep data", buf_level, 3);
        chk("R6 rx reload", cnt_cur, 5);
        chk("R6 rx ctrl", ctrl_q, 16'h8400);
        for (int k = 0; k < 3; k++) begin
            pop(b); chk("R7 rx tail", b, 8'hA0 + 8'(base + 3 + k));
        end
        chk("R7 rrdy off", ev_rrdy, 0);
        pop(b);
        chk("R7 empty pop ignored", buf_level, 0);

        // Repeat-mode transmit
        base = log_n;
        wr_cnt(16'd7);
        wr_ctrl(16'h8605);
        cycles(10);
        chk("R5 repeat xrdy", ev_xrdy, 1);
        push(8'h01); push(8'h02);
        cycles(30);
        chk("R8 repeat sends", log_n - base, 3);
        chk("R8 repeat bytes", {log_byte[base+1], log_byte[base+2]}, {8'h01, 8'h02});
        chk("R8 count frozen", cnt_cur, 7);
        chk("R8 xrdy again", ev_xrdy, 1);
        wr_ctrl(16'h8606);
        cycles(20);
        chk("R8 stop issued", {log_n - base, 30'(log_cmd[base+3])}, {32'd4, 30'd3});
        chk("R8 bus closed", bus_open, 0);
        chk("R8 stop bit clear", ctrl_q, 16'h8604);

        // Repeat-mode receive
        base = log_n;
        wr_ctrl(16'h8405);
        cycles(40);
        chk("R8 rx fills to 4", buf_level, 4);
        chk("R8 rx log", log_n - base, 5);
        chk("R8 rx count frozen", cnt_cur, 7);
        wr_ctrl(16'h8406);
        cycles(20);
        chk("R8 rx stop", log_cmd[base+5], 3);
        chk("R8 rx data kept", buf_level, 4);

        // Data byte refused
        base = log_n;
        nack_idx = base + 2;
        wr_cnt(16'd3);
        wr_ctrl(16'h8603);
        chk("R2 fifo emptied", buf_level, 0);
        cycles(10);
        push(8'h71); push(8'h72); push(8'h73);
        cycles(40);
        chk("R9 nack", ev_nack, 1);
        chk("R9 stop withdrawn", ctrl_q, 16'h8600);
        chk("R9 halted", log_n - base, 3);
        chk("R9 count", cnt_cur, 2);
        chk("R9 byte left", buf_level, 1);
        chk("R9 bus held", bus_open, 1);
        clr(2'b10);
        chk("R11 nack cleared", ev_nack, 0);
        nack_idx = -1;

        // Address refused
        base = log_n;
        nack_idx = base;
        wr_ctrl(16'h8603);
        cycles(15);
        chk("R3 addr nack", ev_nack, 1);
        chk("R3 stop withdrawn", ctrl_q, 16'h8600);
        chk("R3 bus closed", bus_open, 0);
        chk("R3 no more cmds", log_n - base, 1);
        nack_idx = -1;

        // Legacy reset by clearing enable
        push(8'h99);
        wr_ctrl(16'h4000);
        chk("R10 ctrl", ctrl_q, 0);
        chk("R10 counts", {ev_nack, buf_level, cnt_cur}, 0);

        // Zero count with stop
        base = log_n;
        wr_ctrl(16'h8603);
        chk("R10 addr cleared", bus_addr, 0);
        cycles(20);
        chk("R6 zero count stop", {log_n - base, 30'(log_cmd[base+1])}, {32'd2, 30'd3});
        chk("R6 zero count no ardy", ev_ardy, 0);

        // Zero count without stop
        base = log_n;
        wr_ctrl(16'h8601);
        cycles(15);
        chk("R6 zero count ardy", ev_ardy, 1);
        chk("R6 zero count only open", log_n - base, 1);
        chk("R6 zero count master", ctrl_q, 16'h8200);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule